// File: doc/BRIEF.md
# Floating-Point Min/Max and Ordered Compare Unit

This unit picks the smaller or larger of two floating-point operands, or tests whether one is below (or at most) the other, for half (16-bit), single (32-bit) and double (64-bit) formats. Both min and max are offered in two flavours. The conventional one passes a real number through when the other operand is NaN. The NaN-propagating one yields the canonical NaN as soon as either input is NaN.

Each ordered test also comes in two flavours. The signalling one raises the invalid flag on any NaN. The quiet one raises it only for a signalling NaN.

Operands arrive already unboxed, with the active format held in the low bits of a 64-bit bus. The answer is registered: the result and the invalid flag appear one clock after the inputs are presented.

Top module: `fpcm_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `result_q` becomes 0 and `invalid_q` becomes 0. Otherwise the outputs after a rising edge reflect the inputs sampled at that edge, giving a latency of one cycle.
- R2: `fmt_sel` selects the format. 2'b00 is half, 2'b01 is single, and 2'b10 or 2'b11 is double. The operand sits in bits [W-1:0], where W is 16, 32 or 64. A floating-point result is placed in the same bits with every bit above W cleared.
- R3: `op_sel` selects the operation. 3'b000 is min, 3'b001 is max, 3'b010 is NaN-propagating min, 3'b011 is NaN-propagating max, 3'b100 is less-than, 3'b101 is less-or-equal, 3'b110 is quiet less-than and 3'b111 is quiet less-or-equal. For non-NaN inputs, both min variants return the numerically smaller operand and both max variants the larger. Negative zero orders below positive zero.
- R4: In conventional min/max, if exactly one operand is NaN, the other operand is returned. If both are NaN, the canonical NaN is returned.
- R5: In NaN-propagating min/max, any NaN input gives the canonical NaN. The canonical NaN is 0x7E00 for half, 0x7FC00000 for single and 0x7FF8000000000000 for double.
- R6: The compares return 1 or 0 in bit 0, with all other bits cleared. Negative zero equals positive zero. Any compare with a NaN operand returns 0.
- R7: Signalling less-than and less-or-equal raise `invalid_q` whenever either operand is NaN, quiet or signalling.
- R8: Quiet less-than and less-or-equal raise `invalid_q` only for a signalling NaN operand. Otherwise they give the same result as the signalling compares. A NaN is signalling when its most significant mantissa bit is 0 and quiet when that bit is 1.
- R9: Both min/max variants raise `invalid_q` only when an operand is a signalling NaN.
- R10: For half and single, operand bits above the format width have no effect on the result or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | 64 | First operand, format in low bits |
| opnd_b | input | 64 | Second operand, format in low bits |
| fmt_sel | input | 2 | Format select |
| op_sel | input | 3 | Operation select |
| result_q | output | 64 | Registered result (value or 0/1) |
| invalid_q | output | 1 | Registered invalid-operation flag |

## Verification
The result selection and the invalid flag are decided in the same cycle by separate logic. The sharpest case is a conventional min or max with one signalling NaN: the other operand must come out unchanged while the flag rises. The bench provokes this with a signalling NaN beside an ordinary number in each format. It also pairs quiet NaNs with the quiet compares, where the result is 0 and the flag stays low. Both outputs are judged together at the falling edge after the capturing edge.

// File: rtl/fpcm_pkg.sv
`timescale 1ns/1ps
package fpcm_pkg;
  localparam int FP_W    = 64;
  localparam int MAG_W   = FP_W - 1;
  localparam int NUM_FMT = 3;

  typedef enum logic [1:0] {
    FMT_H = 2'b00,
    FMT_S = 2'b01,
    FMT_D = 2'b10
  } fmt_e;

  typedef enum logic [2:0] {
    OP_MIN  = 3'b000,
    OP_MAX  = 3'b001,
    OP_MINP = 3'b010,
    OP_MAXP = 3'b011,
    OP_LT   = 3'b100,
    OP_LE   = 3'b101,
    OP_LTQ  = 3'b110,
    OP_LEQ  = 3'b111
  } op_e;

  typedef struct packed {
    logic             sign;
    logic [MAG_W-1:0] mag;
    logic             nan;
    logic             snan;
    logic             zero;
  } fp_info_t;

  function automatic int exp_w(int idx);
    case (idx)
      0:       return 5;
      1:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int man_w(int idx);
    case (idx)
      0:       return 10;
      1:       return 23;
      default: return 52;
    endcase
  endfunction

  function automatic logic [FP_W-1:0] fmt_mask(logic [1:0] f);
    case (f)
      FMT_H:   return FP_W'(64'h0000_0000_0000_FFFF);
      FMT_S:   return FP_W'(64'h0000_0000_FFFF_FFFF);
      default: return '1;
    endcase
  endfunction

  function automatic logic [FP_W-1:0] canon_nan(logic [1:0] f);
    case (f)
      FMT_H:   return FP_W'(64'h0000_0000_0000_7E00);
      FMT_S:   return FP_W'(64'h0000_0000_7FC0_0000);
      default: return FP_W'(64'h7FF8_0000_0000_0000);
    endcase
  endfunction
endpackage

// File: rtl/fpcm_unpack.sv
`timescale 1ns/1ps
module fpcm_unpack
  import fpcm_pkg::*;
(
  input  logic [FP_W-1:0] raw,
  input  logic [1:0]      fmt,
  output fp_info_t        info
);
  fp_info_t per_fmt [NUM_FMT];

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    localparam int EW = exp_w(g);
    localparam int MW = man_w(g);
    localparam int TW = 1 + EW + MW;
    logic [EW-1:0] ex;
    logic [MW-1:0] mn;
    assign ex = raw[MW +: EW];
    assign mn = raw[0 +: MW];
    assign per_fmt[g] = '{
      sign: raw[TW-1],
      mag:  MAG_W'(raw[TW-2:0]),
      nan:  (&ex) & (|mn),
      snan: (&ex) & (|mn) & ~mn[MW-1],
      zero: ~|raw[TW-2:0]
    };
  end

  always_comb begin
    case (fmt)
      FMT_H:   info = per_fmt[0];
      FMT_S:   info = per_fmt[1];
      default: info = per_fmt[2];
    endcase
  end
endmodule

// File: rtl/fpcm_decide.sv
`timescale 1ns/1ps
module fpcm_decide
  import fpcm_pkg::*;
(
  input  logic [FP_W-1:0] raw_a,
  input  logic [FP_W-1:0] raw_b,
  input  fp_info_t        ia,
  input  fp_info_t        ib,
  input  logic [1:0]      fmt,
  input  logic [2:0]      op,
  output logic [FP_W-1:0] res,
  output logic            inv
);
  logic [FP_W-1:0] a_m, b_m, cnan, min_v, max_v;
  logic both_zero, mag_lt, mag_eq, tot_lt, num_lt, num_eq;
  logic any_nan, both_nan, any_snan;

  assign a_m      = raw_a & fmt_mask(fmt);
  assign b_m      = raw_b & fmt_mask(fmt);
  assign cnan     = canon_nan(fmt);
  assign both_zero = ia.zero & ib.zero;
  assign mag_lt   = ia.mag < ib.mag;
  assign mag_eq   = ia.mag == ib.mag;
  assign any_nan  = ia.nan | ib.nan;
  assign both_nan = ia.nan & ib.nan;
  assign any_snan = ia.snan | ib.snan;

  // total order used by min/max: -0 below +0
  always_comb begin
    if (both_zero)              tot_lt = ia.sign & ~ib.sign;
    else if (ia.sign != ib.sign) tot_lt = ia.sign;
    else if (ia.sign)           tot_lt = ~mag_lt & ~mag_eq;
    else                        tot_lt = mag_lt;
  end

  assign num_eq = both_zero | ((ia.sign == ib.sign) & mag_eq);
  assign num_lt = tot_lt & ~both_zero;
  assign min_v  = tot_lt ? a_m : b_m;
  assign max_v  = tot_lt ? b_m : a_m;

  always_comb begin
    res = '0;
    inv = 1'b0;
    case (op_e'(op))
      OP_MIN, OP_MAX: begin
        inv = any_snan;
        if (both_nan)   res = cnan;
        else if (ia.nan) res = b_m;
        else if (ib.nan) res = a_m;
        else            res = (op[0]) ? max_v : min_v;
      end
      OP_MINP, OP_MAXP: begin
        inv = any_snan;
        if (any_nan) res = cnan;
        else         res = (op[0]) ? max_v : min_v;
      end
      default: begin
        inv    = op[1] ? any_snan : any_nan;
        res[0] = ~any_nan & (op[0] ? (num_lt | num_eq) : num_lt);
      end
    endcase
  end

  // R6: a compare with a NaN operand never reports true
  always_comb begin
    if (op[2] && any_nan) a_cmp_nan_r6: assert (res == '0);
  end
endmodule

// File: rtl/fpcm_unit.sv
`timescale 1ns/1ps
module fpcm_unit
  import fpcm_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [63:0]     opnd_a,
  input  logic [63:0]     opnd_b,
  input  logic [1:0]      fmt_sel,
  input  logic [2:0]      op_sel,
  output logic [63:0]     result_q,
  output logic            invalid_q
);
  fp_info_t        info_a, info_b;
  logic [FP_W-1:0] res_c;
  logic            inv_c;

  fpcm_unpack u_unp_a (.raw(opnd_a), .fmt(fmt_sel), .info(info_a));
  fpcm_unpack u_unp_b (.raw(opnd_b), .fmt(fmt_sel), .info(info_b));

  fpcm_decide u_dec (
    .raw_a(opnd_a), .raw_b(opnd_b), .ia(info_a), .ib(info_b),
    .fmt(fmt_sel), .op(op_sel), .res(res_c), .inv(inv_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q  <= '0;
      invalid_q <= 1'b0;
    end else begin
      result_q  <= res_c;
      invalid_q <= inv_c;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (result_q == '0) && !invalid_q);

  p_snan_flags_r9: assert property (@(posedge clk) disable iff (rst)
    (info_a.snan || info_b.snan) |=> invalid_q);

  p_quiet_no_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (op_sel[2:1] == 2'b11 && !info_a.snan && !info_b.snan) |=> !invalid_q);

  p_sig_nan_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (op_sel[2:1] == 2'b10 && (info_a.nan || info_b.nan)) |=> invalid_q);

  p_prop_canon_r5: assert property (@(posedge clk) disable iff (rst)
    (op_sel[2:1] == 2'b01 && (info_a.nan || info_b.nan))
      |=> result_q == canon_nan($past(fmt_sel)));

  p_pick_operand_r3: assert property (@(posedge clk) disable iff (rst)
    (!op_sel[2] && !info_a.nan && !info_b.nan)
      |=> (result_q == ($past(opnd_a) & fmt_mask($past(fmt_sel))))
       || (result_q == ($past(opnd_b) & fmt_mask($past(fmt_sel)))));
endmodule

// File: tb/sim_fpcm_unit.sv
`timescale 1ns/1ps
module sim_fpcm_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic [1:0]  fmt_sel = 2'b00;
  logic [2:0]  op_sel = 3'b000;
  logic [63:0] result_q;
  logic        invalid_q;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  localparam logic [1:0] H = 2'b00, S = 2'b01, D = 2'b10;
  localparam logic [2:0] MIN = 3'd0, MAX = 3'd1, MINP = 3'd2, MAXP = 3'd3,
                         LT = 3'd4, LE = 3'd5, LTQ = 3'd6, LEQ = 3'd7;

  always #10 clk = ~clk;

  fpcm_unit u0 (.clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
                .fmt_sel(fmt_sel), .op_sel(op_sel),
                .result_q(result_q), .invalid_q(invalid_q));

  task automatic check(string tag, logic [63:0] er, logic ei);
    n_run++;
    if (result_q !== er || invalid_q !== ei) begin
      n_fail++;
      $display("FAIL %s: got res=%h inv=%b, expected res=%h inv=%b",
               tag, result_q, invalid_q, er, ei);
    end
  endtask

  task automatic run(string tag, logic [63:0] a, logic [63:0] b,
                     logic [1:0] f, logic [2:0] o, logic [63:0] er, logic ei);
    @(negedge clk);
    opnd_a = a; opnd_b = b; fmt_sel = f; op_sel = o;
    @(negedge clk);
    check(tag, er, ei);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset state", 64'h0, 1'b0);
  endtask

  task automatic t_minmax_plain();
    run("R3 half min 1,2", 64'h3C00, 64'h4000, H, MIN, 64'h3C00, 0);
    run("R3 half max -1,1", 64'hBC00, 64'h3C00, H, MAX, 64'h3C00, 0);
    run("R3 half min -1,-2", 64'hBC00, 64'hC000, H, MIN, 64'hC000, 0);
    run("R3 single min -2,1", 64'hC000_0000, 64'h3F80_0000, S, MIN, 64'hC000_0000, 0);
    run("R3 double max -3,0.5", 64'hC008_0000_0000_0000, 64'h3FE0_0000_0000_0000,
        D, MAX, 64'h3FE0_0000_0000_0000, 0);
    run("R3 half min +0,-0", 64'h0000, 64'h8000, H, MIN, 64'h8000, 0);
    run("R3 half max -0,+0", 64'h8000, 64'h0000, H, MAX, 64'h0000, 0);
    run("R3 single minp 1,2", 64'h3F80_0000, 64'h4000_0000, S, MINP, 64'h3F80_0000, 0);
  endtask

  task automatic t_std_nan();
    run("R4 half min qnan,1", 64'h7E01, 64'h3C00, H, MIN, 64'h3C00, 0);
    run("R4 R9 single max snan,2", 64'h7F80_0001, 64'h4000_0000, S, MAX, 64'h4000_0000, 1);
    run("R4 double min qnan,qnan", 64'h7FF8_0000_0000_0001, 64'hFFF8_0000_0000_0000,
        D, MIN, 64'h7FF8_0000_0000_0000, 0);
    run("R4 R9 half max 1,snan", 64'h3C00, 64'h7C01, H, MAX, 64'h3C00, 1);
  endtask

  task automatic t_prop_nan();
    run("R5 half minp qnan,1", 64'h7E01, 64'h3C00, H, MINP, 64'h7E00, 0);
    run("R5 single maxp 1,qnan", 64'h3F80_0000, 64'h7FC0_0001, S, MAXP, 64'h7FC0_0000, 0);
    run("R5 R9 double minp snan,1", 64'h7FF0_0000_0000_0001, 64'h3FF0_0000_0000_0000,
        D, MINP, 64'h7FF8_0000_0000_0000, 1);
  endtask

  task automatic t_compare();
    run("R6 half lt 1,2", 64'h3C00, 64'h4000, H, LT, 64'h1, 0);
    run("R6 half le 2,1", 64'h4000, 64'h3C00, H, LE, 64'h0, 0);
    run("R6 half lt -0,+0", 64'h8000, 64'h0000, H, LT, 64'h0, 0);
    run("R6 half le -0,+0", 64'h8000, 64'h0000, H, LE, 64'h1, 0);
    run("R6 double lt -3,0.5", 64'hC008_0000_0000_0000, 64'h3FE0_0000_0000_0000,
        D, LT, 64'h1, 0);
    run("R6 single le 2,2", 64'h4000_0000, 64'h4000_0000, S, LE, 64'h1, 0);
  endtask

  task automatic t_sig_nan();
    run("R7 half lt qnan,1", 64'h7E00, 64'h3C00, H, LT, 64'h0, 1);
    run("R7 single le 1,snan", 64'h3F80_0000, 64'h7F80_0001, S, LE, 64'h0, 1);
  endtask

  task automatic t_quiet();
    run("R8 half ltq qnan,1", 64'h7E00, 64'h3C00, H, LTQ, 64'h0, 0);
    run("R8 double leq 1,qnan", 64'h3FF0_0000_0000_0000, 64'h7FF8_0000_0000_0001,
        D, LEQ, 64'h0, 0);
    run("R8 single ltq snan,1", 64'h7F80_0001, 64'h3F80_0000, S, LTQ, 64'h0, 1);
    run("R8 half leq 1,2", 64'h3C00, 64'h4000, H, LEQ, 64'h1, 0);
    run("R8 double ltq -3,0.5", 64'hC008_0000_0000_0000, 64'h3FE0_0000_0000_0000,
        D, LTQ, 64'h1, 0);
  endtask

  task automatic t_upper_bits();
    run("R10 R2 half min junk", 64'hFFFF_FFFF_FFFF_3C00, 64'h1234_5678_9ABC_4000,
        H, MIN, 64'h3C00, 0);
    run("R10 single lt junk", 64'hDEAD_BEEF_3F80_0000, 64'h0000_0001_4000_0000,
        S, LT, 64'h1, 0);
    run("R10 R2 single max junk", 64'hFFFF_FFFF_3F80_0000, 64'h0000_0000_4000_0000,
        S, MAX, 64'h4000_0000, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_minmax_plain();
    t_std_nan();
    t_prop_nan();
    t_compare();
    t_sig_nan();
    t_quiet();
    t_upper_bits();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule